// File: doc/BRIEF.md
# Coprocessor Instruction Issue Sequencer

This block sits on the host side of a host/coprocessor pair. It hands escape-class instructions to the attached coprocessor over a shared bus. When the host pipeline presents an instruction, the sequencer holds the opcode write until the coprocessor's busy line is low, or starts it at once when the instruction says the wait is not needed. It then moves the instruction's operands one bus cycle at a time. Each operand cycle starts only after the coprocessor raises its request line.

Each instruction carries its opcode, its operand count, one direction bit and one skip-wait bit. For operands going to the coprocessor, the host's memory side supplies the data word. For operands coming back, the sequencer returns the word with a one-cycle valid strobe. The host is released with a one-cycle completion pulse as soon as the last operand has moved, or once the opcode has been written when the count is zero. The host does not wait for the coprocessor to finish computing. The coprocessor's error line is caught in a sticky flag, which the host clears.

Top module: `cpx_issue_seq`

## Requirements
- R1: After a synchronous reset, `ins_ready` is 1, and `bus_req`, `bus_kind`, `host_done`, `opnd_rvalid` and `err_flag` are all 0.
- R2: When an instruction with `ins_nowait`=0 is accepted, no bus cycle starts while `cp_busy` is sampled high. The opcode cycle begins in the cycle after `cp_busy` is first sampled low.
- R3: When an instruction with `ins_nowait`=1 is accepted, the opcode cycle begins in the next cycle, whatever the level of `cp_busy`.
- R4: An opcode cycle drives `bus_kind`=2'b01. `bus_wdata` holds the accepted opcode, zero-extended into the low bits.
- R5: After the opcode cycle, and between operands, a new operand cycle begins only in the cycle after `cp_req` is sampled high. Each such sample starts exactly one operand cycle.
- R6: With `ins_dir`=0, operand cycles use `bus_kind`=2'b10 (data to the coprocessor). With `ins_dir`=1 they use 2'b11 (data from the coprocessor). `bus_wdata` takes the value of `opnd_wdata` sampled when the operand cycle is launched. In the cycle after a 2'b11 cycle is acknowledged, `opnd_rvalid` pulses for one cycle and `opnd_rdata` equals the `bus_rdata` sampled with the acknowledge.
- R7: An instruction produces exactly as many operand cycles as its `ins_nops` value, from 0 up to the counter maximum.
- R8: `host_done` pulses for one cycle, in the cycle after the acknowledge of the last operand cycle, or of the opcode cycle when `ins_nops`=0. `ins_ready` returns to 1 in the following cycle.
- R9: `ins_ready` is 1 only while the sequencer is idle. `ins_valid` is ignored while `ins_ready` is 0.
- R10: `err_flag` becomes 1 in the cycle after `cp_err` is sampled high. It stays 1 until `err_clr` is sampled high. When both are high together, the flag is set.
- R11: Once a bus cycle starts, `bus_req`, `bus_kind` and `bus_wdata` hold steady until `bus_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Host offers an instruction |
| ins_ready | output | 1 | Sequencer idle and able to accept |
| ins_opcode | input | OPW | Instruction opcode |
| ins_nops | input | CNTW | Number of operands to move |
| ins_dir | input | 1 | 1: operands read from coprocessor, 0: written to it |
| ins_nowait | input | 1 | Skip the busy wait before the opcode |
| cp_busy | input | 1 | Coprocessor still executing |
| cp_req | input | 1 | Coprocessor ready for one operand |
| cp_err | input | 1 | Coprocessor error indication |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky error flag |
| bus_req | output | 1 | Coprocessor bus cycle in progress |
| bus_kind | output | 2 | 01 opcode write, 10 data write, 11 data read |
| bus_wdata | output | DW | Write data for the bus cycle |
| bus_ack | input | 1 | End of the current bus cycle |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| opnd_wdata | input | DW | Operand word from host memory side |
| opnd_rdata | output | DW | Operand word returned from coprocessor |
| opnd_rvalid | output | 1 | One-cycle strobe for opnd_rdata |
| host_done | output | 1 | One-cycle release pulse to the host |

## Verification
The hardest situation to reach from the ports is a request line that stays low while the sequencer waits for an operand. In that state the sequencer must hold off, and the host must also try to offer a second instruction, which has to be ignored. The bench can force the request line low or pulse it sparsely, hold the busy line high across acceptance, and vary the acknowledge latency. This parks the sequencer in each waiting state for several cycles. A behavioural model follows every edge and checks that no cycle leaks out and that the stray offer is dropped.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WBUSY  = 3'd1,
    ST_SENDOP = 3'd2,
    ST_WREQ   = 3'd3,
    ST_XFER   = 3'd4,
    ST_DONE   = 3'd5
  } seq_st_e;

  localparam logic [1:0] KIND_NONE = 2'b00;
  localparam logic [1:0] KIND_OPC  = 2'b01;
  localparam logic [1:0] KIND_DWR  = 2'b10;
  localparam logic [1:0] KIND_DRD  = 2'b11;

endpackage

// File: rtl/cpx_seq_fsm.sv
module cpx_seq_fsm
  import cpx_pkg::*;
#(
  parameter int OPW  = 11,
  parameter int CNTW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [OPW-1:0]  ins_opcode,
  input  logic [CNTW-1:0] ins_nops,
  input  logic            ins_dir,
  input  logic            ins_nowait,
  input  logic            cp_busy,
  input  logic            cp_req,
  input  logic            bus_ack,
  output seq_st_e         st,
  output seq_st_e         nxt,
  output logic [OPW-1:0]  opc_sel,
  output logic            dir_q,
  output logic            ins_ready,
  output logic            host_done
);

  logic [CNTW-1:0] cnt_q;
  logic [OPW-1:0]  opc_q;
  logic            last_opnd;

  assign last_opnd = (cnt_q == CNTW'(1));
  assign opc_sel   = (st == ST_IDLE) ? ins_opcode : opc_q;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:   if (ins_valid) nxt = ins_nowait ? ST_SENDOP : ST_WBUSY;
      ST_WBUSY:  if (!cp_busy) nxt = ST_SENDOP;
      ST_SENDOP: if (bus_ack) nxt = (cnt_q == '0) ? ST_DONE : ST_WREQ;
      ST_WREQ:   if (cp_req) nxt = ST_XFER;
      ST_XFER:   if (bus_ack) nxt = last_opnd ? ST_DONE : ST_WREQ;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt_q     <= '0;
      opc_q     <= '0;
      dir_q     <= 1'b0;
      ins_ready <= 1'b1;
      host_done <= 1'b0;
    end else begin
      st        <= nxt;
      ins_ready <= (nxt == ST_IDLE);
      host_done <= (nxt == ST_DONE);
      if (st == ST_IDLE && ins_valid) begin
        cnt_q <= ins_nops;
        opc_q <= ins_opcode;
        dir_q <= ins_dir;
      end else if (st == ST_XFER && bus_ack) begin
        cnt_q <= cnt_q - CNTW'(1);
      end
    end
  end

endmodule

// File: rtl/cpx_bus_drv.sv
module cpx_bus_drv
  import cpx_pkg::*;
#(
  parameter int OPW = 11,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  seq_st_e        st,
  input  seq_st_e        nxt,
  input  logic [OPW-1:0] opc_sel,
  input  logic           dir_q,
  input  logic [DW-1:0]  opnd_wdata,
  input  logic           bus_ack,
  input  logic [DW-1:0]  bus_rdata,
  output logic           bus_req,
  output logic [1:0]     bus_kind,
  output logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  opnd_rdata,
  output logic           opnd_rvalid
);

  localparam int PADW = DW - OPW;

  logic launch_op, launch_xf, rd_ack;

  assign launch_op = (nxt == ST_SENDOP) && (st != ST_SENDOP);
  assign launch_xf = (nxt == ST_XFER) && (st != ST_XFER);
  assign rd_ack    = (st == ST_XFER) && bus_ack && dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req     <= 1'b0;
      bus_kind    <= KIND_NONE;
      bus_wdata   <= '0;
      opnd_rdata  <= '0;
      opnd_rvalid <= 1'b0;
    end else begin
      bus_req <= (nxt == ST_SENDOP) || (nxt == ST_XFER);
      if (nxt == ST_SENDOP)    bus_kind <= KIND_OPC;
      else if (nxt == ST_XFER) bus_kind <= dir_q ? KIND_DRD : KIND_DWR;
      else                     bus_kind <= KIND_NONE;
      if (launch_op)      bus_wdata <= {{PADW{1'b0}}, opc_sel};
      else if (launch_xf) bus_wdata <= opnd_wdata;
      opnd_rvalid <= rd_ack;
      if (rd_ack) opnd_rdata <= bus_rdata;
    end
  end

endmodule

// File: rtl/cpx_err_latch.sv
module cpx_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic cp_err,
  input  logic err_clr,
  output logic err_flag
);

  always_ff @(posedge clk) begin
    if (rst)         err_flag <= 1'b0;
    else if (cp_err) err_flag <= 1'b1;
    else if (err_clr) err_flag <= 1'b0;
  end

endmodule

// File: rtl/cpx_issue_seq.sv
module cpx_issue_seq
  import cpx_pkg::*;
#(
  parameter int OPW  = 11,
  parameter int CNTW = 3,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [OPW-1:0]  ins_opcode,
  input  logic [CNTW-1:0] ins_nops,
  input  logic            ins_dir,
  input  logic            ins_nowait,
  input  logic            cp_busy,
  input  logic            cp_req,
  input  logic            cp_err,
  input  logic            err_clr,
  output logic            err_flag,
  output logic            bus_req,
  output logic [1:0]      bus_kind,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata,
  input  logic [DW-1:0]   opnd_wdata,
  output logic [DW-1:0]   opnd_rdata,
  output logic            opnd_rvalid,
  output logic            host_done
);

  seq_st_e        st, nxt;
  logic [OPW-1:0] opc_sel;
  logic           dir_q;

  cpx_seq_fsm #(.OPW(OPW), .CNTW(CNTW)) u_fsm (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_opcode(ins_opcode),
    .ins_nops(ins_nops), .ins_dir(ins_dir), .ins_nowait(ins_nowait),
    .cp_busy(cp_busy), .cp_req(cp_req), .bus_ack(bus_ack),
    .st(st), .nxt(nxt), .opc_sel(opc_sel), .dir_q(dir_q),
    .ins_ready(ins_ready), .host_done(host_done)
  );

  cpx_bus_drv #(.OPW(OPW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .st(st), .nxt(nxt), .opc_sel(opc_sel),
    .dir_q(dir_q), .opnd_wdata(opnd_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_kind(bus_kind),
    .bus_wdata(bus_wdata), .opnd_rdata(opnd_rdata), .opnd_rvalid(opnd_rvalid)
  );

  cpx_err_latch u_err (
    .clk(clk), .rst(rst), .cp_err(cp_err), .err_clr(err_clr), .err_flag(err_flag)
  );

endmodule

// File: rtl/cpx_issue_seq_chk.sv
module cpx_issue_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic          ins_nowait,
  input logic          cp_busy,
  input logic          cp_req,
  input logic          cp_err,
  input logic          err_clr,
  input logic          err_flag,
  input logic          bus_req,
  input logic [1:0]    bus_kind,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          opnd_rvalid,
  input logic          host_done
);

  // R2 R3
  opcode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_kind == 2'b01 && !$past(bus_req)) |->
      ($past(!cp_busy) || $past(ins_ready && ins_valid && ins_nowait)));

  // R5
  opnd_paced_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_kind[1] && !$past(bus_req)) |-> $past(cp_req));

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_kind) && $stable(bus_wdata)));

  // R8
  release_once_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> (!host_done && ins_ready));

  // R6
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    opnd_rvalid |-> $past(bus_req && bus_ack && bus_kind == 2'b11));

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    cp_err |=> err_flag);

  // R10
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ins_ready |-> (!bus_req && !host_done));

endmodule

bind cpx_issue_seq cpx_issue_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_nowait(ins_nowait), .cp_busy(cp_busy), .cp_req(cp_req),
  .cp_err(cp_err), .err_clr(err_clr), .err_flag(err_flag),
  .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .opnd_rvalid(opnd_rvalid), .host_done(host_done)
);

// File: tb/test_cpx_issue_seq.sv
module test_cpx_issue_seq;

  localparam int OPW = 11, CNTW = 3, DW = 32;
  localparam int M_IDLE = 0, M_WB = 1, M_SOP = 2, M_WR = 3, M_XF = 4, M_DN = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic ins_valid = 0, ins_dir = 0, ins_nowait = 0;
  logic [OPW-1:0] ins_opcode = '0;
  logic [CNTW-1:0] ins_nops = '0;
  logic cp_busy = 0, cp_req = 0, cp_err = 0, err_clr = 0, bus_ack = 0;
  logic [DW-1:0] bus_rdata = '0, opnd_wdata = 32'h1357_9BDF;
  logic ins_ready, err_flag, bus_req, opnd_rvalid, host_done;
  logic [1:0] bus_kind;
  logic [DW-1:0] bus_wdata, opnd_rdata;

  int checks = 0, errors = 0, cyc = 0;
  int req_mode = 0, ack_lat = 0, wcnt = 0;
  int exp_n = 0, xfers = 0;
  bit prev_req = 0, started = 0;

  int m_st = M_IDLE, m_n = 0;
  bit m_dir = 0, m_rv = 0, m_err = 0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  logic [OPW-1:0] m_opc = '0;
  logic [31:0] lfsr = 32'hACE1_0001;

  always #10 clk = ~clk;

  cpx_issue_seq #(.OPW(OPW), .CNTW(CNTW), .DW(DW)) i_cpx_issue_seq (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_opcode(ins_opcode), .ins_nops(ins_nops), .ins_dir(ins_dir),
    .ins_nowait(ins_nowait), .cp_busy(cp_busy), .cp_req(cp_req),
    .cp_err(cp_err), .err_clr(err_clr), .err_flag(err_flag),
    .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .opnd_wdata(opnd_wdata),
    .opnd_rdata(opnd_rdata), .opnd_rvalid(opnd_rvalid), .host_done(host_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = M_IDLE; m_rv = 0; m_err = 0; m_wd = '0; m_rd = '0;
    end else begin
      started = 1;
      m_rv = 0;
      case (m_st)
        M_IDLE: if (ins_valid) begin
          m_opc = ins_opcode; m_n = int'(ins_nops); m_dir = ins_dir;
          if (ins_nowait) begin m_st = M_SOP; m_wd = DW'(ins_opcode); end
          else m_st = M_WB;
        end
        M_WB: if (!cp_busy) begin m_st = M_SOP; m_wd = DW'(m_opc); end
        M_SOP: if (bus_ack) m_st = (m_n == 0) ? M_DN : M_WR;
        M_WR: if (cp_req) begin m_st = M_XF; m_wd = opnd_wdata; end
        M_XF: if (bus_ack) begin
          if (m_dir) begin m_rv = 1; m_rd = bus_rdata; end
          m_n--;
          m_st = (m_n == 0) ? M_DN : M_WR;
        end
        default: m_st = M_IDLE;
      endcase
      m_err = cp_err | (m_err & ~err_clr);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    logic [1:0] ek;
    if (!rst && started) begin
      ek = (m_st == M_SOP) ? 2'b01 : (m_st == M_XF) ? (m_dir ? 2'b11 : 2'b10) : 2'b00;
      chk(ins_ready == (m_st == M_IDLE), "R9 ins_ready", 64'(ins_ready), 64'(m_st == M_IDLE));
      chk(bus_req == (m_st == M_SOP || m_st == M_XF), "R2 bus_req", 64'(bus_req), 64'(m_st == M_SOP || m_st == M_XF));
      chk(bus_kind == ek, "R4/R6 bus_kind", 64'(bus_kind), 64'(ek));
      if (bus_req) chk(bus_wdata == m_wd, "R11 bus_wdata", 64'(bus_wdata), 64'(m_wd));
      chk(host_done == (m_st == M_DN), "R8 host_done", 64'(host_done), 64'(m_st == M_DN));
      chk(err_flag == m_err, "R10 err_flag", 64'(err_flag), 64'(m_err));
      chk(opnd_rvalid == m_rv, "R6 opnd_rvalid", 64'(opnd_rvalid), 64'(m_rv));
      if (m_rv) chk(opnd_rdata == m_rd, "R6 opnd_rdata", 64'(opnd_rdata), 64'(m_rd));
      if (bus_req && !prev_req && bus_kind != 2'b01) xfers++;
      if (host_done) begin
        chk(xfers == exp_n, "R7 operand count", 64'(xfers), 64'(exp_n));
        xfers = 0;
      end
      prev_req = bus_req;
    end
  end

  // bus responder, request line and operand source
  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    opnd_wdata = opnd_wdata + 32'h0101_0037;
    if (bus_ack) begin bus_ack = 0; wcnt = 0; end
    else if (bus_req) begin
      if (wcnt >= ack_lat) begin bus_ack = 1; bus_rdata = lfsr; end
      else wcnt++;
    end
    case (req_mode)
      0: cp_req = 1;
      1: cp_req = (cyc % 3 == 0);
      default: cp_req = 0;
    endcase
  end

  task automatic issue(input logic [OPW-1:0] opc, input int n, input bit dir, input bit nw);
    while (ins_ready !== 1'b1) @(negedge clk);
    exp_n = n;
    ins_valid = 1; ins_opcode = opc; ins_nops = CNTW'(n); ins_dir = dir; ins_nowait = nw;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (host_done !== 1'b1 && t < 500) begin @(negedge clk); t++; end
    chk(t < 500, "R8 release reached", 64'(t), 64'(0));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ins_ready == 1 && bus_req == 0 && bus_kind == 0 && host_done == 0 &&
        opnd_rvalid == 0 && err_flag == 0, "R1 reset state",
        {ins_ready, bus_req, bus_kind, host_done, opnd_rvalid, err_flag}, 7'b1000000);

    // R2 busy gate
    cp_busy = 1;
    issue(11'h1A5, 2, 0, 0);
    repeat (4) begin
      chk(bus_req == 0, "R2 held by busy", 64'(bus_req), 64'(0));
      @(negedge clk);
    end
    cp_busy = 0;
    @(negedge clk);
    chk(bus_req == 1 && bus_kind == 2'b01, "R2 opcode after busy low", {bus_req, bus_kind}, 3'b101);
    chk(bus_wdata == 32'h1A5, "R4 opcode word", 64'(bus_wdata), 64'h1A5);
    wait_done();

    // R3 skip wait, zero operands
    cp_busy = 1;
    issue(11'h7C3, 0, 0, 1);
    chk(bus_req == 1 && bus_kind == 2'b01, "R3 opcode despite busy", {bus_req, bus_kind}, 3'b101);
    wait_done();
    cp_busy = 0;

    // R5 pacing with request held low, R9 stray offer ignored
    req_mode = 2;
    issue(11'h055, 3, 1, 1);
    repeat (3) @(negedge clk);
    ins_valid = 1; ins_opcode = 11'h7FF; ins_nops = 3'd1; ins_nowait = 1;
    repeat (6) begin
      chk(!(bus_req && bus_kind[1]), "R5 no operand without request", 64'(bus_req), 64'(0));
      @(negedge clk);
    end
    ins_valid = 0;
    req_mode = 1;
    wait_done();
    chk(ins_ready == 1, "R9 idle after stray offer", 64'(ins_ready), 64'(1));

    // R6 write direction with slow acks, R7 maximum count
    ack_lat = 2;
    req_mode = 0;
    issue(11'h321, 7, 0, 0);
    wait_done();
    issue(11'h0F0, 7, 1, 1);
    wait_done();
    ack_lat = 0;
    req_mode = 1;
    issue(11'h444, 1, 1, 0);
    wait_done();

    // R10 sticky error
    cp_err = 1; @(negedge clk); cp_err = 0;
    repeat (3) @(negedge clk);
    chk(err_flag == 1, "R10 flag sticky", 64'(err_flag), 64'(1));
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk(err_flag == 0, "R10 flag cleared", 64'(err_flag), 64'(0));
    cp_err = 1; err_clr = 1; @(negedge clk); cp_err = 0; err_clr = 0; @(negedge clk);
    chk(err_flag == 1, "R10 set wins over clear", 64'(err_flag), 64'(1));

    // error arriving mid-instruction does not disturb the sequence
    req_mode = 0;
    issue(11'h2AA, 2, 0, 1);
    cp_err = 1; @(negedge clk); cp_err = 0;
    wait_done();

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule